// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a TLB miss in hardware. Given a 32-bit virtual address, the kind of access wanted and the current page-table base, it fetches a super-table entry from memory. When that entry is valid, it fetches the matching entry from a second-level table. It then hands back either a translation that is ready to load into a TLB, or a fault. An invalid super-table entry stops the walk after one read, so second-level tables only need to exist where the super table marks them valid.

The address splits into a 10-bit super index (bits 31:22), a 10-bit second-level index (bits 21:12) and a 12-bit page offset (bits 11:0). Every entry is one 32-bit word:

| Bits | Meaning |
|------|---------|
| 31 | valid |
| 30 | read right |
| 29 | write right |
| 28 | execute right |
| 19:0 | frame number |

In a super entry the frame number locates the second-level table. In a second-level entry it is the physical page. Memory traffic uses a word-read port: the block holds each request until memory accepts it, and then waits any number of cycles for the response.

Top module: `pt_walker`

## Requirements
- R1: When a request is accepted, the first memory read goes to base + (vaddr[31:22] × 4).
- R2: A super entry with bit 31 clear ends the walk with a page fault (`walk_fault`=1, `fault_is_prot`=0). No second memory read is made.
- R3: When the super entry is valid, the second read goes to (entry[19:0] << 12) + (vaddr[21:12] × 4).
- R4: A second-level entry with bit 31 clear gives a page fault (`fault_is_prot`=0).
- R5: A valid second-level entry that lacks a requested right gives a protection fault (`fault_is_prot`=1). `acc_kind` bit 2 asks for read and is matched against entry bit 30. `acc_kind` bit 1 asks for write and is matched against entry bit 29. `acc_kind` bit 0 asks for execute and is matched against entry bit 28.
- R6: A successful walk raises `walk_done`. While `walk_done` is high, `tlb_pte` equals the second-level entry word and `tlb_vpn` equals vaddr[31:12]. `walk_done` and `walk_fault` are never high together.
- R7: `walk_done` and `walk_fault` each last exactly one cycle per walk.
- R8: While a walk is busy, `req_valid` is ignored. No extra memory reads are made and the result belongs to the first request.
- R9: A memory request keeps its valid and address unchanged until `mem_req_ready` is seen. Any delay before acceptance and any response latency still give the correct result.
- R10: The base is captured when the request is accepted. Changing `pt_base` during a walk has no effect on that walk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| req_valid | input | 1 | start a walk (taken only when idle) |
| req_vaddr | input | 32 | virtual address to translate |
| acc_kind | input | 3 | requested rights: bit 2 read, bit 1 write, bit 0 execute |
| pt_base | input | 32 | physical address of the super table |
| busy | output | 1 | a walk is in progress |
| mem_req_valid | output | 1 | word read request |
| mem_req_addr | output | 32 | byte address of the word to read |
| mem_req_ready | input | 1 | memory accepts the request |
| mem_rsp_valid | input | 1 | read data valid |
| mem_rsp_data | input | 32 | read data |
| walk_done | output | 1 | one-cycle pulse on success |
| walk_fault | output | 1 | one-cycle pulse on a fault |
| fault_is_prot | output | 1 | with `walk_fault`: 1 = protection fault, 0 = page fault |
| tlb_vpn | output | 20 | virtual page number of the walk |
| tlb_pte | output | 32 | resulting second-level entry |

## Verification
Two things can land in the same cycle: a new request and the end of the current walk. The bench keeps `req_valid` high with a different address for the whole walk, including the cycle in which the result pulse is driven. It then lowers the request and counts memory reads. A correct block shows exactly two reads and the translation of the first address. A second walk, a changed result or a stretched pulse is reported. The bench also slows the memory's accept and response timing so that a request must wait while the walk state is held.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int L1_BITS  = 10,
  parameter int L2_BITS  = 10,
  parameter int OFF_BITS = 12,
  parameter int PPN_W    = 20,
  parameter int VA_W     = L1_BITS + L2_BITS + OFF_BITS,
  parameter int ADDR_W   = PPN_W + OFF_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [VA_W-1:0]      req_vaddr,
  input  logic [2:0]           acc_kind,
  input  logic [ADDR_W-1:0]    pt_base,
  output logic                 busy,
  output logic                 mem_req_valid,
  output logic [ADDR_W-1:0]    mem_req_addr,
  input  logic                 mem_req_ready,
  input  logic                 mem_rsp_valid,
  input  logic [31:0]          mem_rsp_data,
  output logic                 walk_done,
  output logic                 walk_fault,
  output logic                 fault_is_prot,
  output logic [VA_W-OFF_BITS-1:0] tlb_vpn,
  output logic [31:0]          tlb_pte
);
  localparam int VBIT = 31;
  localparam int RTOP = 30;

  typedef enum logic [2:0] {IDLE, READ_L1, WAIT_L1, READ_L2, WAIT_L2, DONE} st_t;

  st_t                st;
  logic [VA_W-1:0]    va_q;
  logic [2:0]         acc_q;
  logic [ADDR_W-1:0]  base_q;
  logic [PPN_W-1:0]   frame_q;
  logic [31:0]        pte_q;
  logic               flt_q, prot_q;

  logic [L1_BITS-1:0] l1_idx;
  logic [L2_BITS-1:0] l2_idx;
  logic [ADDR_W-1:0]  addr_l1, addr_l2;
  logic               lacks_right;

  assign l1_idx  = va_q[VA_W-1 -: L1_BITS];
  assign l2_idx  = va_q[OFF_BITS +: L2_BITS];
  assign addr_l1 = base_q + {{(ADDR_W-L1_BITS-2){1'b0}}, l1_idx, 2'b00};
  assign addr_l2 = {frame_q, {OFF_BITS{1'b0}}} + {{(ADDR_W-L2_BITS-2){1'b0}}, l2_idx, 2'b00};
  assign lacks_right = |(acc_q & ~mem_rsp_data[RTOP -: 3]);

  assign busy          = (st != IDLE);
  assign mem_req_valid = (st == READ_L1) || (st == READ_L2);
  assign mem_req_addr  = (st == READ_L2) ? addr_l2 : addr_l1;
  assign walk_done     = (st == DONE) && !flt_q;
  assign walk_fault    = (st == DONE) && flt_q;
  assign fault_is_prot = walk_fault && prot_q;
  assign tlb_vpn       = va_q[VA_W-1:OFF_BITS];
  assign tlb_pte       = pte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      va_q    <= '0;
      acc_q   <= '0;
      base_q  <= '0;
      frame_q <= '0;
      pte_q   <= '0;
      flt_q   <= 1'b0;
      prot_q  <= 1'b0;
    end else begin
      unique case (st)
        IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          acc_q  <= acc_kind;
          base_q <= pt_base;
          flt_q  <= 1'b0;
          prot_q <= 1'b0;
          st     <= READ_L1;
        end
        READ_L1: if (mem_req_ready) st <= WAIT_L1;
        WAIT_L1: if (mem_rsp_valid) begin
          if (!mem_rsp_data[VBIT]) begin
            flt_q <= 1'b1;
            st    <= DONE;
          end else begin
            frame_q <= mem_rsp_data[PPN_W-1:0];
            st      <= READ_L2;
          end
        end
        READ_L2: if (mem_req_ready) st <= WAIT_L2;
        WAIT_L2: if (mem_rsp_valid) begin
          pte_q <= mem_rsp_data;
          if (!mem_rsp_data[VBIT]) begin
            flt_q <= 1'b1;
          end else if (lacks_right) begin
            flt_q  <= 1'b1;
            prot_q <= 1'b1;
          end
          st <= DONE;
        end
        DONE:    st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module pt_walker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              walk_done,
  input logic              walk_fault,
  input logic              fault_is_prot,
  input logic [31:0]       tlb_pte
);
  assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_done || walk_fault) |=> !(walk_done || walk_fault));

  assert_done_fault_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(walk_done && walk_fault));

  assert_done_valid_pte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |-> tlb_pte[31]);

  assert_prot_valid_pte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_is_prot |-> (walk_fault && tlb_pte[31]));
endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .walk_done(walk_done), .walk_fault(walk_fault),
  .fault_is_prot(fault_is_prot), .tlb_pte(tlb_pte)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [2:0]  acc_kind = '0;
  logic [31:0] pt_base = 32'h0000_1000;
  logic        busy, mem_req_valid, walk_done, walk_fault, fault_is_prot;
  logic [31:0] mem_req_addr, mem_rsp_data, tlb_pte;
  logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [19:0] tlb_vpn;

  int checks = 0, fails = 0, nreads = 0, cyc = 0;
  int rdy_dly = 0, rsp_dly = 1;
  logic [31:0] rd_addr [0:3];
  logic [31:0] mem [0:4095];

  always #10 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .acc_kind(acc_kind), .pt_base(pt_base), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .walk_done(walk_done), .walk_fault(walk_fault),
    .fault_is_prot(fault_is_prot), .tlb_vpn(tlb_vpn), .tlb_pte(tlb_pte)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // memory model: accept after rdy_dly cycles, answer rsp_dly cycles later
  initial begin
    logic [31:0] a;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        repeat (rdy_dly) @(negedge clk);
        mem_req_ready = 1'b1;
        a = mem_req_addr;
        @(negedge clk);
        mem_req_ready = 1'b0;
        if (nreads < 4) rd_addr[nreads] = a;
        nreads++;
        repeat (rsp_dly) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem[a[13:2]];
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = 32'hDEAD_BEEF;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  // kind: 0 success, 1 page fault, 2 protection fault
  task automatic walk(input [31:0] va, input [2:0] acc, input int kind, input [31:0] epte,
                      input int ereads, input [31:0] ea1, input [31:0] ea2,
                      input string tag, input bit hold, input bit swap_base);
    int n;
    @(negedge clk);
    nreads = 0;
    req_valid = 1'b1; req_vaddr = va; acc_kind = acc;
    @(negedge clk);
    if (hold) req_vaddr = va ^ 32'h0040_1000;
    else begin req_valid = 1'b0; req_vaddr = ~va; acc_kind = 3'b000; end
    if (swap_base) pt_base = 32'h0000_0000;
    n = 0;
    while (!(walk_done || walk_fault) && n < 300) begin @(negedge clk); n++; end
    req_valid = 1'b0;
    chk(n < 300, {tag, " R9 walk completes"}, n, 0);
    chk(walk_done == (kind == 0), {tag, " R6 done flag"}, walk_done, kind == 0);
    chk(walk_fault == (kind != 0), {tag, " R2/R4 fault flag"}, walk_fault, kind != 0);
    chk(fault_is_prot == (kind == 2), {tag, " R5 fault type"}, fault_is_prot, kind == 2);
    if (kind == 0) begin
      chk(tlb_pte == epte, {tag, " R6 pte"}, tlb_pte, epte);
      chk(tlb_vpn == va[31:12], {tag, " R6 vpn"}, tlb_vpn, va[31:12]);
    end
    chk(rd_addr[0] == ea1, {tag, " R1 first read addr"}, rd_addr[0], ea1);
    if (ereads > 1) chk(rd_addr[1] == ea2, {tag, " R3 second read addr"}, rd_addr[1], ea2);
    @(negedge clk);
    chk(!walk_done && !walk_fault, {tag, " R7 pulse one cycle"}, {walk_done, walk_fault}, 0);
    repeat (6) @(negedge clk);
    chk(nreads == ereads, {tag, " R2/R8 read count"}, nreads, ereads);
    chk(!busy, {tag, " R8 idle after walk"}, busy, 0);
    pt_base = 32'h0000_1000;
  endtask

  task automatic t_reset();
    chk(!busy && !mem_req_valid && !walk_done && !walk_fault,
        "reset R7 outputs quiet", {busy, mem_req_valid, walk_done, walk_fault}, 0);
  endtask

  task automatic t_success();
    walk(32'h00C0_5123, 3'b100, 0, 32'hF001_2345, 2, 32'h100C, 32'h2014, "ok_R6", 0, 0);
    walk(32'h00C0_5123, 3'b111, 0, 32'hF001_2345, 2, 32'h100C, 32'h2014, "allrights_R5", 0, 0);
  endtask

  task automatic t_l1_invalid();
    walk(32'h01C0_0000, 3'b100, 1, 0, 1, 32'h101C, 0, "l1inv_R2", 0, 0);
  endtask

  task automatic t_l2_invalid();
    walk(32'h00C0_6000, 3'b100, 1, 0, 2, 32'h100C, 32'h2018, "l2inv_R4", 0, 0);
  endtask

  task automatic t_prot();
    walk(32'h00C0_8FFF, 3'b010, 2, 0, 2, 32'h100C, 32'h2020, "write_R5", 0, 0);
    walk(32'h00C0_8FFF, 3'b001, 2, 0, 2, 32'h100C, 32'h2020, "exec_R5", 0, 0);
    walk(32'h00C0_8FFF, 3'b100, 0, 32'hC000_0ABC, 2, 32'h100C, 32'h2020, "readok_R5", 0, 0);
  endtask

  task automatic t_top_index();
    walk(32'hFFFF_F000, 3'b010, 0, 32'hA005_5555, 2, 32'h1FFC, 32'h3FFC, "top_R3", 0, 0);
  endtask

  task automatic t_latency();
    rdy_dly = 3; rsp_dly = 5;
    walk(32'h00C0_5123, 3'b100, 0, 32'hF001_2345, 2, 32'h100C, 32'h2014, "slow_R9", 0, 0);
    rdy_dly = 0; rsp_dly = 0;
    walk(32'hFFFF_F000, 3'b010, 0, 32'hA005_5555, 2, 32'h1FFC, 32'h3FFC, "fast_R9", 0, 0);
    rsp_dly = 1;
  endtask

  task automatic t_busy_ignore();
    walk(32'h00C0_5123, 3'b100, 0, 32'hF001_2345, 2, 32'h100C, 32'h2014, "hold_R8", 1, 0);
  endtask

  task automatic t_base_capture();
    walk(32'h00C0_5123, 3'b100, 0, 32'hF001_2345, 2, 32'h100C, 32'h2014, "base_R10", 0, 1);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    for (int i = 0; i < 4; i++) rd_addr[i] = 32'h0;
    mem[1027] = 32'h8000_0002;
    mem[2047] = 32'h8000_0003;
    mem[2048 + 5] = 32'hF001_2345;
    mem[2048 + 8] = 32'hC000_0ABC;
    mem[4095] = 32'hA005_5555;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_success();
    t_l1_invalid();
    t_l2_invalid();
    t_prot();
    t_top_index();
    t_latency();
    t_busy_ignore();
    t_base_capture();
    finish_run();
  end
endmodule